// File: doc/BRIEF.md
# Single-Channel Demand-Mode DMA Channel

This block is one DMA channel for an 8-bit system bus. Software sets it up with byte-wide I/O writes: a mask bit, a mode byte, a 16-bit memory address, a 16-bit transfer count and a 4-bit page value. A shared byte pointer decides whether each address or count write lands in the low or the high byte. Once the channel is unmasked and in demand mode, it performs one transfer per clock for as long as the peripheral holds its request line. For each transfer it drives the acknowledge, the 20-bit memory address and a memory read or write strobe.

The count is programmed as the length minus one. The transfer made while the count reads zero is the last one. On that transfer the channel pulses a terminal-count output together with the acknowledge. It then latches a status flag and masks itself, so it stops even if the request stays high.

The 16-bit address counter steps up or down within a 64 KiB page and never carries into the page value. If the request drops partway through, the channel pauses and keeps its place. It resumes from the same address and count when the request returns.

Top module: `dmac_chan`

## Requirements
- R1: After reset the channel is masked, the status byte reads 0x00, the address output reads 0x00000 and no acknowledge or strobe is driven even while a request is present.
- R2: A write with select 0 loads the mask from data bit 0 (1 masks, 0 unmasks). While the mask is set no acknowledge is given and the address and count do not change.
- R3: A write with select 2 sends the next address or count write to the low byte. Every write with select 3 (address) or select 4 (count) goes to the byte the pointer names and then toggles the pointer, so the second write of a pair fills the high byte.
- R4: A write with select 1 loads the mode byte only when bits 1:0 equal the channel number (3). Otherwise the write is ignored. The mode byte fields are: bit 2 set means write to memory and clear means read from memory; bit 5 set means decrement; bits 7:6 give the transfer mode. Requests are serviced only when bits 7:6 are 00 (demand).
- R5: Each transfer asserts the memory write strobe when mode bit 2 is set and the memory read strobe when it is clear, always together with the acknowledge.
- R6: The address output is the 4-bit page (written with select 5) over the 16-bit address. The 16-bit address steps by one per transfer, up or down according to mode bit 5. It wraps between 0xFFFF and 0x0000 without changing the page.
- R7: A programmed count of N gives exactly N+1 transfers. The terminal-count output is high only during the last of them, coincident with the acknowledge.
- R8: After the last transfer, status bit 0 is set and the channel is masked, so no further acknowledge is given while the request stays high.
- R9: A status read strobe clears status bit 0 in the following cycle. A terminal count in the same cycle takes priority.
- R10: The acknowledge is given only while the request is high. When the request drops, the address and count hold their values, and servicing resumes from them when the request returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select (0 mask, 1 mode, 2 pointer clear, 3 address, 4 count, 5 page) |
| wr_data_i | input | 8 | Write data |
| stat_rd_i | input | 1 | Status read strobe, clears the terminal-count flag |
| stat_o | output | 8 | Status byte, bit 0 terminal-count flag |
| drq_i | input | 1 | Peripheral request |
| ack_o | output | 1 | Transfer acknowledge |
| tc_o | output | 1 | Terminal-count pulse on the last transfer |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| addr_o | output | 20 | Memory address, page over offset |

## Verification
On every cycle the assertions check the following. An acknowledge never appears while the channel is masked or without a request. The terminal-count pulse always rides on an acknowledge and is always followed by the mask and the status flag. The address counter moves by exactly one per transfer and holds otherwise, and a pointer clear always leaves the low byte selected. Only the directed scenarios can show the rest: the end-to-end effects of register programming, such as byte ordering, mode-write filtering, the exact N+1 transfer length, the wrap within the page, and resuming from the same address after a request gap.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NBYTES = 2;
  localparam int unsigned PAGE_W = 4;

  typedef enum logic [2:0] {
    SEL_MASK   = 3'd0,
    SEL_MODE   = 3'd1,
    SEL_PTRCLR = 3'd2,
    SEL_ADDR   = 3'd3,
    SEL_CNT    = 3'd4,
    SEL_PAGE   = 3'd5
  } wsel_e;

  localparam logic [1:0] XMODE_DEMAND = 2'b00;
endpackage

// File: rtl/dmac_wcnt.sv
module dmac_wcnt
  import dmac_pkg::*;
#(
  parameter int unsigned NB = NBYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NB-1:0]     ld_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              step_i,
  input  logic              down_i,
  output logic [NB*BYTE_W-1:0] val_o,
  output logic              zero_o
);
  localparam int unsigned W = NB * BYTE_W;

  logic [W-1:0] q, ld_val;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign ld_val[b*BYTE_W +: BYTE_W] = ld_i[b] ? data_i : q[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (|ld_i)  q <= ld_val;
    else if (step_i) q <= down_i ? q - W'(1) : q + W'(1);
  end

  assign val_o  = q;
  assign zero_o = (q == '0);

  // R6
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !(|ld_i) && !down_i) |=> val_o == $past(val_o) + W'(1));
  // R6
  step_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !(|ld_i) && down_i) |=> val_o == $past(val_o) - W'(1));
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !(|ld_i)) |=> $stable(val_o));
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
#(
  parameter int unsigned CHAN_ID = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              stat_rd_i,
  input  logic              drq_i,
  input  logic              cnt_zero_i,
  output logic [NBYTES-1:0] addr_ld_o,
  output logic [NBYTES-1:0] cnt_ld_o,
  output logic              step_o,
  output logic              down_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [BYTE_W-1:0] stat_o,
  output logic              ack_o,
  output logic              tc_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o
);
  logic              mask_q, hi_ptr_q, to_mem_q, dec_q, tc_flag_q;
  logic [1:0]        xmode_q;
  logic [PAGE_W-1:0] page_q;
  logic              wr_mask, wr_mode, wr_clr, wr_addr, wr_cnt, wr_page, svc, last;
  logic [NBYTES-1:0] byte_sel;
  logic              unused_mode;

  assign wr_mask = wr_en_i && (wr_sel_i == SEL_MASK);
  assign wr_mode = wr_en_i && (wr_sel_i == SEL_MODE) && (wr_data_i[1:0] == 2'(CHAN_ID));
  assign wr_clr  = wr_en_i && (wr_sel_i == SEL_PTRCLR);
  assign wr_addr = wr_en_i && (wr_sel_i == SEL_ADDR);
  assign wr_cnt  = wr_en_i && (wr_sel_i == SEL_CNT);
  assign wr_page = wr_en_i && (wr_sel_i == SEL_PAGE);
  assign unused_mode = ^wr_data_i[4:3];

  assign byte_sel  = hi_ptr_q ? NBYTES'(2) : NBYTES'(1);
  assign addr_ld_o = wr_addr ? byte_sel : '0;
  assign cnt_ld_o  = wr_cnt  ? byte_sel : '0;

  assign svc  = !mask_q && (xmode_q == XMODE_DEMAND) && drq_i;
  assign last = svc && cnt_zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= 1'b1;
      hi_ptr_q  <= 1'b0;
      to_mem_q  <= 1'b0;
      dec_q     <= 1'b0;
      xmode_q   <= XMODE_DEMAND;
      page_q    <= '0;
      tc_flag_q <= 1'b0;
    end else begin
      if (wr_mask)   mask_q <= wr_data_i[0];
      else if (last) mask_q <= 1'b1;
      if (wr_clr)                hi_ptr_q <= 1'b0;
      else if (wr_addr || wr_cnt) hi_ptr_q <= ~hi_ptr_q;
      if (wr_mode) begin
        to_mem_q <= wr_data_i[2];
        dec_q    <= wr_data_i[5];
        xmode_q  <= wr_data_i[7:6];
      end
      if (wr_page) page_q <= wr_data_i[PAGE_W-1:0];
      if (last)           tc_flag_q <= 1'b1;
      else if (stat_rd_i) tc_flag_q <= 1'b0;
    end
  end

  assign step_o   = svc;
  assign down_o   = dec_q;
  assign page_o   = page_q;
  assign stat_o   = {{(BYTE_W-1){1'b0}}, tc_flag_q};
  assign ack_o    = svc;
  assign tc_o     = last;
  assign mem_rd_o = svc && !to_mem_q;
  assign mem_wr_o = svc && to_mem_q;

  // R2
  ack_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !mask_q);
  // R10
  ack_drq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> drq_i);
  // R7
  tc_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (ack_o && (mem_rd_o != mem_wr_o)));
  // R8
  tc_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !wr_mask) |=> (mask_q && tc_flag_q && !ack_o));
  // R9
  stat_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !tc_o) |=> !tc_flag_q);
  // R3
  ptr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> !hi_ptr_q);
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int unsigned CHAN_ID = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [2:0]  wr_sel_i,
  input  logic [7:0]  wr_data_i,
  input  logic        stat_rd_i,
  output logic [7:0]  stat_o,
  input  logic        drq_i,
  output logic        ack_o,
  output logic        tc_o,
  output logic        mem_rd_o,
  output logic        mem_wr_o,
  output logic [19:0] addr_o
);
  localparam int unsigned OFS_W = NBYTES * BYTE_W;

  logic [NBYTES-1:0] addr_ld, cnt_ld;
  logic              step, down, cnt_zero, addr_zero;
  logic [PAGE_W-1:0] page;
  logic [OFS_W-1:0]  addr_ofs, cnt_val;
  logic              unused_cnt;

  dmac_ctrl #(.CHAN_ID(CHAN_ID)) u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .stat_rd_i, .drq_i,
    .cnt_zero_i(cnt_zero), .addr_ld_o(addr_ld), .cnt_ld_o(cnt_ld),
    .step_o(step), .down_o(down), .page_o(page), .stat_o,
    .ack_o, .tc_o, .mem_rd_o, .mem_wr_o
  );

  dmac_wcnt #(.NB(NBYTES)) u_addr (
    .clk_i, .rst_ni, .ld_i(addr_ld), .data_i(wr_data_i),
    .step_i(step), .down_i(down), .val_o(addr_ofs), .zero_o(addr_zero)
  );

  dmac_wcnt #(.NB(NBYTES)) u_cnt (
    .clk_i, .rst_ni, .ld_i(cnt_ld), .data_i(wr_data_i),
    .step_i(step), .down_i(1'b1), .val_o(cnt_val), .zero_o(cnt_zero)
  );

  assign unused_cnt = addr_zero ^ (^cnt_val);
  assign addr_o     = {page, addr_ofs};

  // R6
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !(wr_en_i && wr_sel_i == SEL_PAGE)) |=> $stable(addr_o[19:16]));
endmodule

// File: tb/dmac_chan_tb_top.sv
`timescale 1ns/1ps
module dmac_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic        stat_rd = 1'b0;
  logic [7:0]  stat;
  logic        drq = 1'b0;
  logic        ack, tc, mem_rd, mem_wr;
  logic [19:0] addr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dmac_chan dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .stat_rd_i(stat_rd), .stat_o(stat), .drq_i(drq),
    .ack_o(ack), .tc_o(tc), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .addr_o(addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge, returns at the next one
  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic program_run(input logic [15:0] a, input logic [15:0] c, input logic [7:0] mode);
    wr(3'd0, 8'h01);
    wr(3'd1, mode);
    wr(3'd2, 8'h00);
    wr(3'd3, a[7:0]);  wr(3'd3, a[15:8]);
    wr(3'd4, c[7:0]);  wr(3'd4, c[15:8]);
    wr(3'd0, 8'h00);
  endtask

  task automatic stat_clear();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic t_reset();
    drq = 1'b1;
    #1;
    chk("R1 ack", ack, 0);
    chk("R1 stat", stat, 8'h00);
    chk("R1 addr", addr, 20'h0);
    chk("R1 strobes", {mem_rd, mem_wr, tc}, 0);
    @(negedge clk);
    drq = 1'b0;
  endtask

  task automatic t_byte_ptr();
    wr(3'd5, 8'h05);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h34); wr(3'd3, 8'h12);
    #1 chk("R3 lo/hi pair", addr, 20'h51234);
    wr(3'd3, 8'hAA);
    #1 chk("R3 third write low", addr, 20'h512AA);
    wr(3'd3, 8'h77);
    #1 chk("R3 fourth write high", addr, 20'h577AA);
    wr(3'd3, 8'h11);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h22);
    #1 chk("R3 clear returns to low", addr, 20'h57722);
  endtask

  task automatic t_basic_wrap();
    program_run(16'hFFFE, 16'h0002, 8'h07);
    drq = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R7 ack", ack, 1);
      chk("R6 addr wrap in page", addr, (i == 0) ? 20'h5FFFE : (i == 1) ? 20'h5FFFF : 20'h50000);
      chk("R7 tc", tc, (i == 2));
      chk("R5 write strobe", {mem_wr, mem_rd}, 2'b10);
      @(negedge clk);
    end
    #1;
    chk("R8 stop on tc", ack, 0);
    chk("R8 status flag", stat, 8'h01);
    drq = 1'b0;
    @(negedge clk);
    stat_clear();
    #1 chk("R9 read clears", stat, 8'h00);
  endtask

  task automatic t_pause();
    program_run(16'h1000, 16'h0003, 8'h03);
    drq = 1'b1;
    for (int i = 0; i < 2; i++) begin
      #1;
      chk("R6 addr", addr, 20'h51000 + i);
      chk("R5 read strobe", {mem_wr, mem_rd}, 2'b01);
      @(negedge clk);
    end
    drq = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R10 no ack without drq", ack, 0);
      chk("R10 addr holds", addr, 20'h51002);
      @(negedge clk);
    end
    drq = 1'b1;
    #1 chk("R10 resume addr", addr, 20'h51002);
    chk("R10 resume tc", tc, 0);
    @(negedge clk);
    #1 chk("R10 resume last addr", addr, 20'h51003);
    chk("R7 tc after 4", tc, 1);
    @(negedge clk);
    #1 chk("R8 masked after tc", ack, 0);
    drq = 1'b0;
    @(negedge clk);
    stat_clear();
  endtask

  task automatic t_decrement();
    program_run(16'h0001, 16'h0002, 8'h23);
    drq = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R6 decrement", addr, (i == 0) ? 20'h50001 : (i == 1) ? 20'h50000 : 20'h5FFFF);
      chk("R7 tc dec", tc, (i == 2));
      @(negedge clk);
    end
    #1 chk("R8 dec stop", ack, 0);
    drq = 1'b0;
    @(negedge clk);
    stat_clear();
  endtask

  task automatic t_mask();
    program_run(16'h2000, 16'h0009, 8'h03);
    drq = 1'b1;
    #1 chk("R2 unmasked ack", ack, 1);
    chk("R2 addr", addr, 20'h52000);
    @(negedge clk);
    wr(3'd0, 8'h01);
    #1 chk("R2 masked no ack", ack, 0);
    chk("R2 addr at mask", addr, 20'h52002);
    @(negedge clk);
    #1 chk("R2 addr held while masked", addr, 20'h52002);
    wr(3'd0, 8'h00);
    #1 chk("R2 unmask resumes", {ack, addr}, {1'b1, 20'h52002});
    drq = 1'b0;
    @(negedge clk);
    wr(3'd0, 8'h01);
  endtask

  task automatic t_mode_filter();
    wr(3'd1, 8'h03);
    wr(3'd1, 8'h05);
    program_run(16'h3000, 16'h0000, 8'h07);
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h03);
    wr(3'd1, 8'h05);
    wr(3'd0, 8'h00);
    drq = 1'b1;
    #1 chk("R4 other channel ignored", {ack, mem_rd, mem_wr}, 3'b110);
    chk("R7 single transfer tc", tc, 1);
    chk("R6 addr", addr, 20'h53000);
    @(negedge clk);
    #1 chk("R8 single stop", ack, 0);
    drq = 1'b0;
    @(negedge clk);
    stat_rd = 1'b1;
    #1 chk("R9 flag before clear", stat, 8'h01);
    @(negedge clk);
    stat_rd = 1'b0;
    wr(3'd1, 8'h43);
    wr(3'd0, 8'h00);
    drq = 1'b1;
    #1 chk("R4 non-demand not serviced", ack, 0);
    chk("R9 cleared", stat, 8'h00);
    @(negedge clk);
    drq = 1'b0;
    wr(3'd0, 8'h01);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_ptr();
    t_basic_wrap();
    t_pause();
    t_decrement();
    t_mask();
    t_mode_filter();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule